// File: doc/BRIEF.md
# DMA Ready Handshake Generator

This block drives the two DMA request lines of one serial channel when that channel runs in block-transfer DMA mode. Each line works as a set/clear latch, so the DMA controller gets a burst-sized window of work instead of a request that toggles on every FIFO change.

The transmit line rises once the number of free transmit FIFO slots reaches a programmed threshold. It then stays up until the transmit FIFO is completely full. The receive line rises when the receive FIFO holds at least its threshold count, or when a receive timeout is flagged. It then stays up until the receive FIFO is drained. A receive FIFO error flag drops it at once.

Occupancy, free-space counts, thresholds and status flags all arrive on ports from the surrounding FIFO logic. Both outputs are registered.

Top module: `dma_rdy_gen`

## Requirements
- R1: While rst_ni is low, tx_rdy_o and rx_rdy_o are 0. They are cleared asynchronously the moment rst_ni falls.
- R2: With dma_mode_i high, tx_rdy_o is 1 one clock after tx_free_i >= tx_trig_i with tx_free_i nonzero.
- R3: Once set, tx_rdy_o stays 1 while tx_free_i is between 1 and tx_trig_i-1. If it was 0, it stays 0 in that range.
- R4: tx_rdy_o is 0 one clock after tx_free_i equals 0, which means the transmit FIFO is full.
- R5: rx_rdy_o is 1 one clock after rx_level_i >= rx_trig_i, provided rx_level_i is nonzero and rx_err_i is 0.
- R6: A cycle with rx_timeout_i high sets rx_rdy_o on the next clock even when rx_level_i is below rx_trig_i, provided rx_level_i is nonzero and rx_err_i is 0.
- R7: Once set, rx_rdy_o holds while rx_level_i stays nonzero. It clears one clock after rx_level_i equals 0.
- R8: rx_rdy_o is 0 one clock after any cycle with rx_err_i high, whatever the level and timeout inputs are.
- R9: dma_mode_i low forces both outputs to 0 on the next clock.
- R10: When a set condition and a clear condition are true in the same cycle, the output is 0 on the next clock.
- R11: Counts range from 0 to 64 (7 bits). The outputs change only on a rising clock edge, one cycle after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dma_mode_i | input | 1 | Block-transfer DMA mode enable |
| tx_free_i | input | 7 | Free transmit FIFO locations, 0..64 |
| tx_trig_i | input | 7 | Transmit threshold in free locations |
| rx_level_i | input | 7 | Filled receive FIFO locations, 0..64 |
| rx_trig_i | input | 7 | Receive threshold in filled locations |
| rx_timeout_i | input | 1 | Receive timeout event |
| rx_err_i | input | 1 | Receive FIFO holds an errored entry |
| tx_rdy_o | output | 1 | Transmit DMA ready |
| rx_rdy_o | output | 1 | Receive DMA ready |

## Verification
For several thresholds, including the extremes 1 and 64, the counts are ramped fully up and then fully down. A ramp against a reference latch shows the difference between a hysteresis latch and a plain comparator, because the two disagree only on the return path between the threshold and the empty or full boundary. Timeout pulses at low fill show that a timeout sets the receive line without the threshold being met. Error pulses, DMA-mode drops and set/clear collisions show which condition has priority. An asynchronous reset applied mid-burst checks that the outputs clear without waiting for a clock edge.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
  localparam int unsigned FIFO_DEPTH = 64;
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/dma_rdy_cell.sv
module dma_rdy_cell
  import dma_rdy_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  cnt_t cnt_i,
  input  cnt_t trig_i,
  input  logic aux_set_i,
  input  logic aux_clr_i,
  output logic rdy_o
);
  logic set_c, clr_c, rdy_q;

  // set from threshold or side event; clear at boundary (zero) or side error
  assign set_c = (cnt_i >= trig_i) || aux_set_i;
  assign clr_c = (cnt_i == '0) || aux_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdy_q <= 1'b0;
    else if (!en_i)   rdy_q <= 1'b0;
    else if (clr_c)   rdy_q <= 1'b0; // clear has priority
    else if (set_c)   rdy_q <= 1'b1;
  end

  assign rdy_o = rdy_q;

  // R2 / R5: threshold reached with nonzero count sets the line
  a_r2_r5_threshold_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i >= trig_i && cnt_i != '0 && !aux_clr_i) |=> rdy_o);
  // R4 / R7 / R8 / R10: boundary or error clears
  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 || aux_clr_i) |=> !rdy_o);
  // R3 / R7: hysteresis hold
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i < trig_i && cnt_i != '0 && !aux_set_i && !aux_clr_i)
      |=> (rdy_o == $past(rdy_o)));
  // R9: mode disable forces inactive
  a_r9_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rdy_o);
  // R11: counts stay within FIFO range
  a_r11_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= cnt_t'(FIFO_DEPTH));
endmodule

// File: rtl/dma_rdy_gen.sv
module dma_rdy_gen
  import dma_rdy_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_mode_i,
  input  logic [CNT_W-1:0] tx_free_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             rx_timeout_i,
  input  logic             rx_err_i,
  output logic             tx_rdy_o,
  output logic             rx_rdy_o
);
  // tx: free count hits zero when FIFO is full
  dma_rdy_cell u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (dma_mode_i),
    .cnt_i    (tx_free_i),
    .trig_i   (tx_trig_i),
    .aux_set_i(1'b0),
    .aux_clr_i(1'b0),
    .rdy_o    (tx_rdy_o)
  );

  // rx: level hits zero when FIFO is empty
  dma_rdy_cell u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (dma_mode_i),
    .cnt_i    (rx_level_i),
    .trig_i   (rx_trig_i),
    .aux_set_i(rx_timeout_i),
    .aux_clr_i(rx_err_i),
    .rdy_o    (rx_rdy_o)
  );

  // R1: outputs low during reset
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_rdy_o && !rx_rdy_o));
  // R8: error drops receive line
  a_r8_err_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_i |=> !rx_rdy_o);
  // R6: timeout sets receive line
  a_r6_timeout_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_mode_i && rx_timeout_i && rx_level_i != '0 && !rx_err_i) |=> rx_rdy_o);
endmodule

// File: tb/sim_dma_rdy_gen.sv
module sim_dma_rdy_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [6:0] tf = 7'd0, tt = 7'd1, rl = 7'd0, rt = 7'd1;
  logic       tmo = 1'b0, err = 1'b0;
  logic       tx_rdy, rx_rdy;

  int checks = 0;
  int errors = 0;
  bit exp_tx = 1'b0, exp_rx = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_rdy_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .dma_mode_i(mode),
    .tx_free_i(tf), .tx_trig_i(tt), .rx_level_i(rl), .rx_trig_i(rt),
    .rx_timeout_i(tmo), .rx_err_i(err),
    .tx_rdy_o(tx_rdy), .rx_rdy_o(rx_rdy)
  );

  task automatic chk(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (tf=%0d tt=%0d rl=%0d rt=%0d)",
               req, act, exp, tf, tt, rl, rt);
    end
  endtask

  // drive at negedge, model one register, compare at next negedge
  task automatic step(input bit en, input int f, input int ftrig,
                      input int l, input int ltrig, input bit t, input bit e);
    bit ntx, nrx, tset, tclr, rset, rclr;
    string ttag, rtag;
    mode = en; tf = 7'(f); tt = 7'(ftrig); rl = 7'(l); rt = 7'(ltrig);
    tmo = t; err = e;
    tset = (f >= ftrig); tclr = (f == 0);
    rset = (l >= ltrig) || t; rclr = (l == 0) || e;
    if (!en)       begin ntx = 0; ttag = "R9"; end
    else if (tclr) begin ntx = 0; ttag = tset ? "R10" : "R4"; end
    else if (tset) begin ntx = 1; ttag = "R2"; end
    else           begin ntx = exp_tx; ttag = "R3"; end
    if (!en)       begin nrx = 0; rtag = "R9"; end
    else if (e)    begin nrx = 0; rtag = rset ? "R10" : "R8"; end
    else if (rclr) begin nrx = 0; rtag = rset ? "R10" : "R7"; end
    else if (t && l < ltrig) begin nrx = 1; rtag = "R6"; end
    else if (rset) begin nrx = 1; rtag = "R5"; end
    else           begin nrx = exp_rx; rtag = "R7"; end
    @(posedge clk);
    @(negedge clk);
    exp_tx = ntx; exp_rx = nrx;
    chk(ttag, tx_rdy, exp_tx);
    chk(rtag, rx_rdy, exp_rx);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R11: watchdog expired, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int trigs[6] = '{1, 8, 16, 32, 56, 64};
    repeat (3) @(negedge clk);
    chk("R1", tx_rdy, 1'b0);
    chk("R1", rx_rdy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // ramp sweeps: rx fills up then drains; tx free mirrors it
    foreach (trigs[i]) begin
      for (int c = 0; c <= 64; c++) step(1, 64 - c, trigs[i], c, trigs[i], 0, 0);
      for (int c = 64; c >= 0; c--) step(1, 64 - c, trigs[i], c, trigs[i], 0, 0);
    end

    // R11 latency: input change visible only after the edge
    step(1, 40, 16, 20, 16, 0, 0);
    step(1, 10, 16, 10, 16, 0, 0);  // hold region: remains set
    tf = 7'd0; rl = 7'd0;
    #1;
    chk("R11", tx_rdy, 1'b1);
    chk("R11", rx_rdy, 1'b1);
    step(1, 0, 16, 0, 16, 0, 0);

    // R6: timeout at low fill
    for (int l = 1; l < 8; l++) begin
      step(1, 64, 32, l, 32, 0, 0);
      step(1, 64, 32, l, 32, 1, 0);
      step(1, 64, 32, l, 32, 0, 0);
      step(1, 64, 32, 0, 32, 0, 0);
    end
    step(1, 64, 32, 0, 32, 1, 0);   // R10: timeout with empty fifo

    // R8 / R10: error against set conditions
    step(1, 64, 8, 20, 8, 0, 0);
    step(1, 64, 8, 20, 8, 0, 1);
    step(1, 64, 8, 20, 8, 1, 1);
    step(1, 64, 8, 20, 8, 0, 0);
    step(1, 0, 0, 20, 8, 0, 0);     // tx trig 0 and full: R10

    // R9: mode drop mid-burst
    step(1, 40, 8, 40, 8, 0, 0);
    step(0, 40, 8, 40, 8, 0, 0);
    step(0, 40, 8, 40, 8, 1, 0);
    step(1, 4, 8, 4, 8, 0, 0);      // hold region stays low after disable

    // R1: async reset mid-burst
    step(1, 40, 8, 40, 8, 0, 0);
    #2 rst_n = 1'b0;
    #1;
    chk("R1", tx_rdy, 1'b0);
    chk("R1", rx_rdy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_tx = 0; exp_rx = 0;
    step(1, 4, 8, 4, 8, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule